// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control part of a 12-bit successive-approximation converter. It has an eight-way input selector and reads out through one byte-wide bus. A falling edge on the convert/read line, taken while the enable is high, starts a conversion. The block then clears its approximation register and tests one bit per clock, most significant bit first. On each step it drives a trial code to the internal DAC and keeps or drops the bit according to a single comparator input. Once the last bit is decided, the result is copied into an output latch. The busy flag drops one clock after that copy. A conversion cannot be stopped or restarted once it has begun.

The result is read over an 8-bit port. The select line picks either the upper eight result bits or the lower four bits followed by four zeros. The port floats whenever the convert/read line is low or the enable is low. The three channel-address inputs go straight through to the analog selector with no latch.

The sequencer has four named states. IDLE waits for a start. RESOLVE spends twelve cycles, one per bit. LOAD copies the result into the output latch. FINISH holds busy high for one more cycle. The transitions are: IDLE to RESOLVE on a qualified start edge, RESOLVE to RESOLVE while bits remain, RESOLVE to LOAD after bit 0, LOAD to FINISH, and FINISH to IDLE.

Top module: `sarseq_top`

## Requirements
- R1: A conversion starts only when `rc_n` is sampled high on one clock edge and low on the next while `ce` is high. A falling edge with `ce` low starts nothing.
- R2: On the edge that starts a conversion, the working register is cleared. In the following cycle `trial_code` is 0x800.
- R3: Once started, a conversion cannot be stopped or restarted. Further `rc_n` edges during it leave `busy` held for the same duration and leave the result unchanged.
- R4: `busy` goes high after the start edge and stays high for exactly 14 cycles. It then falls, and the state returns to IDLE.
- R5: The result latch is loaded on the edge one cycle before `busy` falls. When the comparator reports `cmp_ge` = 1 exactly when the input is at or above the trial code, the latched result equals the input code.
- R6: `data_oe` is 1 only while both `ce` and `rc_n` are 1. Otherwise `data_out` is high impedance.
- R7: With `sel_lo` = 0, `data_out` shows result bits 11..4. With `sel_lo` = 1, it shows result bits 3..0 in positions 7..4 and zeros in positions 3..0.
- R8: The code is straight offset binary. The lowest input reads 0x000 and full scale reads 0xFFF.
- R9: `chan_out` equals `chan_in` in the same cycle, and its value is taken as channel number 0 to 7.
- R10: While `rst` is high (synchronous, active high), the result latch clears, `busy` stays low and the sequencer returns to IDLE.
- R11: In RESOLVE step i (i = 0..11), `trial_code` holds the bits already decided above bit 11-i, a one in bit 11-i, and zeros below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Enable for both convert and read |
| rc_n | input | 1 | Low: convert (start on falling edge); high: read |
| sel_lo | input | 1 | 0: upper byte; 1: low nibble padded with zeros |
| chan_in | input | 3 | Channel number requested |
| chan_out | output | 3 | Channel number to the analog selector |
| cmp_ge | input | 1 | Comparator: input at or above trial code |
| trial_code | output | 12 | Trial code to the internal DAC |
| busy | output | 1 | High while a conversion runs |
| data_oe | output | 1 | High while the data port is driven |
| data_out | output | 8 | Tri-state result byte |

## Verification
Inputs are driven on the falling clock edge, and outputs are sampled at falling edges. With the start edge counted as cycle 0, `busy` reads high at the falling edges of cycles 0 through 13 and low at cycle 14. The trial code for step i is sampled at the falling edge of cycle i. The read port and `chan_out` are combinational from the inputs, so they are checked one time step after the select or enable changes. The bench converts every one of the 4096 input codes through a modelled comparator and checks both bytes against the code. It also traces the trial sequence for one code and checks it bit by bit.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_LOAD    = 2'd2,
        ST_FINISH  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/sarseq_edge.sv
module sarseq_edge (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic rc_n,
    output logic start_o
);
    logic rc_q;

    always_ff @(posedge clk) begin
        if (rst) rc_q <= 1'b0;
        else     rc_q <= rc_n;
    end

    // falling edge of the convert/read line, qualified by enable
    assign start_o = ce & rc_q & ~rc_n;
endmodule

// File: rtl/sarseq_fsm.sv
module sarseq_fsm
    import sarseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic last_i,
    output logic clr_o,
    output logic step_o,
    output logic load_o,
    output logic busy_o
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_RESOLVE;
            ST_RESOLVE: if (last_i)  state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        clr_o  = 1'b0;
        step_o = 1'b0;
        load_o = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                clr_o  = start_i;
            end
            ST_RESOLVE: step_o = 1'b1;
            ST_LOAD:    load_o = 1'b1;
            ST_FINISH:  busy_o = 1'b1;
            default:    busy_o = 1'b0;
        endcase
    end

    a_r4_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !load_o && state_q != ST_FINISH) |=> busy_o);
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                step_i,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] work_o,
    output logic                last_o
);
    localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] work_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            mask_q <= '0;
        end else if (clr_i) begin
            work_q <= '0;
            mask_q <= TOP_BIT;
        end else if (step_i) begin
            if (cmp_ge) work_q <= work_q | mask_q;
            mask_q <= mask_q >> 1;
        end
    end

    assign trial_o = work_q | mask_q;
    assign work_o  = work_q;
    assign last_o  = mask_q[0];

    a_r11_mask_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q));
    a_r2_first_trial: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (trial_o == TOP_BIT));
    a_r3_no_reload: assert property (@(posedge clk) disable iff (rst)
        (step_i && !mask_q[0]) |=> (mask_q == ($past(mask_q) >> 1)));
endmodule

// File: rtl/sarseq_readout.sv
module sarseq_readout #(
    parameter int RES_BITS = 12,
    parameter int BUS_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [RES_BITS-1:0] work_i,
    input  logic                ce,
    input  logic                rc_n,
    input  logic                sel_lo,
    output logic                oe_o,
    output logic [BUS_BITS-1:0] data_o
);
    localparam int LOW_BITS = RES_BITS - BUS_BITS;
    localparam int PAD_BITS = BUS_BITS - LOW_BITS;

    logic [RES_BITS-1:0] res_q;
    logic [BUS_BITS-1:0] byte_sel;

    always_ff @(posedge clk) begin
        if (rst)         res_q <= '0;
        else if (load_i) res_q <= work_i;
    end

    always_comb begin
        if (sel_lo) byte_sel = {res_q[LOW_BITS-1:0], {PAD_BITS{1'b0}}};
        else        byte_sel = res_q[RES_BITS-1:LOW_BITS];
    end

    assign oe_o   = ce & rc_n;
    assign data_o = oe_o ? byte_sel : {BUS_BITS{1'bz}};

    a_r5_latch_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (res_q == $past(res_q)));
endmodule

// File: rtl/sarseq_top.sv
module sarseq_top #(
    parameter int RES_BITS = 12,
    parameter int BUS_BITS = 8,
    parameter int CH_BITS  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic                rc_n,
    input  logic                sel_lo,
    input  logic [CH_BITS-1:0]  chan_in,
    output logic [CH_BITS-1:0]  chan_out,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] trial_code,
    output logic                busy,
    output logic                data_oe,
    output logic [BUS_BITS-1:0] data_out
);
    logic start, clr, step, load, last;
    logic [RES_BITS-1:0] work;

    assign chan_out = chan_in;

    sarseq_edge u_edge (
        .clk(clk), .rst(rst), .ce(ce), .rc_n(rc_n), .start_o(start)
    );

    sarseq_fsm u_fsm (
        .clk(clk), .rst(rst), .start_i(start), .last_i(last),
        .clr_o(clr), .step_o(step), .load_o(load), .busy_o(busy)
    );

    sarseq_sar #(.RES_BITS(RES_BITS)) u_sar (
        .clk(clk), .rst(rst), .clr_i(clr), .step_i(step), .cmp_ge(cmp_ge),
        .trial_o(trial_code), .work_o(work), .last_o(last)
    );

    sarseq_readout #(.RES_BITS(RES_BITS), .BUS_BITS(BUS_BITS)) u_rd (
        .clk(clk), .rst(rst), .load_i(load), .work_i(work),
        .ce(ce), .rc_n(rc_n), .sel_lo(sel_lo),
        .oe_o(data_oe), .data_o(data_out)
    );

    a_r5_load_before_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(load, 2));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !load);
endmodule

// File: tb/sim_sarseq_top.sv
module sim_sarseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b1;
    logic        rc_n = 1'b1;
    logic        sel_lo = 1'b0;
    logic [2:0]  chan_in = 3'd0;
    logic [2:0]  chan_out;
    logic        cmp_ge;
    logic [11:0] trial_code;
    logic        busy;
    logic        data_oe;
    logic [7:0]  data_out;
    logic [11:0] target = 12'd0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign cmp_ge = (target >= trial_code);

    sarseq_top u0 (
        .clk(clk), .rst(rst), .ce(ce), .rc_n(rc_n), .sel_lo(sel_lo),
        .chan_in(chan_in), .chan_out(chan_out), .cmp_ge(cmp_ge),
        .trial_code(trial_code), .busy(busy), .data_oe(data_oe),
        .data_out(data_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_result(input string req, input logic [11:0] exp);
        rc_n = 1'b1; ce = 1'b1;
        sel_lo = 1'b0; #1;
        chk(req, {24'd0, data_out}, {24'd0, exp[11:4]});
        sel_lo = 1'b1; #1;
        chk(req, {24'd0, data_out}, {24'd0, exp[3:0], 4'h0});
        sel_lo = 1'b0;
    endtask

    // start on a falling rc_n with rc_n already high for at least one edge
    task automatic convert(input logic [11:0] tgt, input bit glitch, input bit trace,
                           output int busy_len);
        logic [11:0] exp_trial;
        target = tgt;
        @(negedge clk) rc_n = 1'b0;
        @(negedge clk);
        busy_len = 0;
        while (busy && busy_len < 40) begin
            if (trace && busy_len < 12) begin
                exp_trial = (tgt & ~((12'd1 << (12 - busy_len)) - 12'd1))
                          | (12'd1 << (11 - busy_len));
                chk("R11 trial step", {20'd0, trial_code}, {20'd0, exp_trial});
            end
            if (glitch && busy_len == 3) rc_n = 1'b1;
            if (glitch && busy_len == 5) rc_n = 1'b0;
            if (glitch && busy_len == 7) rc_n = 1'b1;
            busy_len++;
            @(negedge clk);
        end
        rc_n = 1'b1;
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", {31'd0, busy}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R10: cleared result after reset
        read_result("R10 reset result", 12'h000);
        chk("R10 busy after reset", {31'd0, busy}, 32'd0);

        // R9: channel pass-through
        for (int c = 0; c < 8; c++) begin
            chan_in = c[2:0]; #1;
            chk("R9 chan pass", {29'd0, chan_out}, c);
        end

        // R6: port enable combinations
        rc_n = 1'b0; ce = 1'b1; #1; chk("R6 oe rc low", {31'd0, data_oe}, 32'd0);
        rc_n = 1'b1; ce = 1'b0; #1; chk("R6 oe ce low", {31'd0, data_oe}, 32'd0);
        rc_n = 1'b0; ce = 1'b0; #1; chk("R6 oe both low", {31'd0, data_oe}, 32'd0);
        rc_n = 1'b1; ce = 1'b1; #1; chk("R6 oe both high", {31'd0, data_oe}, 32'd1);

        // R1: falling edge with ce low starts nothing
        @(negedge clk) begin ce = 1'b0; rc_n = 1'b0; end
        repeat (3) begin
            @(negedge clk);
            chk("R1 no start when disabled", {31'd0, busy}, 32'd0);
        end
        rc_n = 1'b1;
        @(negedge clk) ce = 1'b1;
        @(negedge clk);
        chk("R1 no start on enable rise", {31'd0, busy}, 32'd0);

        // R2/R11/R4: traced conversion
        convert(12'hA5C, 1'b0, 1'b1, len);
        chk("R4 busy length", len, 14);
        read_result("R5 traced result", 12'hA5C);

        // R3: mid-conversion edges ignored
        convert(12'h3C7, 1'b1, 1'b0, len);
        chk("R3 busy length with glitches", len, 14);
        read_result("R3 result with glitches", 12'h3C7);

        // R8: endpoints
        convert(12'h000, 1'b0, 1'b0, len);
        read_result("R8 zero scale", 12'h000);
        convert(12'hFFF, 1'b0, 1'b0, len);
        read_result("R8 full scale", 12'hFFF);

        // R5/R7: sweep all codes
        for (int t = 0; t < 4096; t++) begin
            convert(t[11:0], 1'b0, 1'b0, len);
            read_result("R7 sweep byte", t[11:0]);
            if (len != 14) chk("R4 sweep busy length", len, 14);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule